// File: doc/BRIEF.md
# Transition-Limiting Bus Inversion Codec

This block sits on a wide bidirectional memory data path. It limits how many wires change state from one beat to the next. The data word is split into byte lanes. Every lane gets one extra polarity wire. For each beat the transmit side compares the incoming byte with the value the lane drove last. If sending the byte unchanged would toggle too many wires, it sends the complement and raises the polarity wire. In a group of nine wires (eight data bits and the polarity bit), no more than four switch between transfers.

The last driven value of every lane is kept across idle cycles and across successive commands, so a new burst is coded against whatever the bus last carried. A synchronous clear returns that history to all zeros. The transmit path has one register stage. The receive path is combinational: it restores each received byte by XOR with its replicated polarity bit. Two-beat bursts are simply two consecutive valid beats. The codec needs no burst framing.

Top module: `dbi_ac_codec`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid`, `tx_line_data` and `tx_line_inv` are all zero.
- R2: `tx_valid` equals the value `in_valid` had one clock earlier. Each accepted beat appears on the lines one cycle after it is presented.
- R3: Lane k is the nine wires `tx_line_data[8k+7:8k]` plus `tx_line_inv[k]`. Between two consecutive driven beats with no history clear in between, at most 4 of those nine wires change in any lane.
- R4: On every valid output beat, `tx_line_data` XOR each `tx_line_inv[k]` replicated over its byte equals the data presented one cycle earlier.
- R5: Let d be the number of data bits in which a new byte differs from the lane's last driven byte. The lane is sent inverted (polarity bit 1) when d > 4, or when d = 4 and the lane's last polarity bit is 1. Otherwise it is sent true (polarity bit 0).
- R6: In a cycle with `in_valid` and `hist_clr` both low, `tx_line_data` and `tx_line_inv` keep their values.
- R7: `hist_clr` alone sets every lane's driven byte and polarity bit to zero on the next cycle. With `in_valid` also high, that beat is coded against an all-zero history.
- R8: History is not reset between beats, bursts or idle gaps. The first beat after any idle gap is coded against the last driven lane state.
- R9: `rx_data[8k+7:8k]` equals `rx_line_data[8k+7:8k]` XOR `rx_line_inv[k]` replicated eight times, combinationally.
- R10: Each lane decides its polarity only from its own byte and its own history, whatever the other lanes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hist_clr | input | 1 | Clears the per-lane driven-state history |
| in_valid | input | 1 | Beat on `in_data` is to be transmitted |
| in_data | input | DATA_W | Unencoded transmit data |
| tx_valid | output | 1 | Lines carry a freshly encoded beat |
| tx_line_data | output | DATA_W | Encoded data as driven onto the bus |
| tx_line_inv | output | DATA_W/LANE_W | Per-lane polarity wires |
| rx_line_data | input | DATA_W | Data as received from the bus |
| rx_line_inv | input | DATA_W/LANE_W | Received per-lane polarity wires |
| rx_data | output | DATA_W | Restored receive data |

## Verification
The bench targets the tie at exactly four differing bits. A design that ignored the previous polarity bit would let five wires switch there, and one that always inverted on a tie would break the hand-computed lane values. Idle gaps between bursts check that history survives. A design that reset history per burst would code the next beat against zero and give different lines. The bench also clears history alone and together with a valid beat, drives all-ones and all-zeros patterns, and mixes lanes so that cross-lane coupling would show.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

   // Polarity decision for one lane: flip when keeping the byte would
   // toggle more than half the lane, breaking the tie on the prior flag.
   function automatic logic choose_invert(input int unsigned diff,
                                          input int unsigned half,
                                          input logic        prev_inv);
      return (diff > half) || ((diff == half) && prev_inv);
   endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hist_clr,
   input  logic              in_valid,
   input  logic [LANE_W-1:0] in_byte,
   output logic [LANE_W-1:0] line_byte,
   output logic              line_inv
);
   localparam int unsigned HALF = LANE_W / 2;
   localparam int          CW   = $clog2(LANE_W + 1);

   logic [LANE_W-1:0] base_byte;
   logic              base_inv;
   logic [CW-1:0]     diff_cnt;
   logic              flip;
   logic [LANE_W-1:0] next_byte;

   // History seen by this beat: cleared state wins over held state.
   always_comb begin
      base_byte = hist_clr ? '0   : line_byte;
      base_inv  = hist_clr ? 1'b0 : line_inv;
      diff_cnt  = CW'($countones(in_byte ^ base_byte));
      flip      = dbi_pkg::choose_invert(32'(diff_cnt), HALF, base_inv);
      next_byte = flip ? ~in_byte : in_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_byte <= '0;
         line_inv  <= 1'b0;
      end else if (in_valid) begin
         line_byte <= next_byte;
         line_inv  <= flip;
      end else if (hist_clr) begin
         line_byte <= '0;
         line_inv  <= 1'b0;
      end
   end
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] line_byte,
   input  logic              line_inv,
   output logic [LANE_W-1:0] data_byte
);
   always_comb data_byte = line_byte ^ {LANE_W{line_inv}};
endmodule

// File: rtl/dbi_ac_codec.sv
module dbi_ac_codec #(
   parameter int DATA_W = 128,
   parameter int LANE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hist_clr,
   input  logic                       in_valid,
   input  logic [DATA_W-1:0]          in_data,
   output logic                       tx_valid,
   output logic [DATA_W-1:0]          tx_line_data,
   output logic [DATA_W/LANE_W-1:0]   tx_line_inv,
   input  logic [DATA_W-1:0]          rx_line_data,
   input  logic [DATA_W/LANE_W-1:0]   rx_line_inv,
   output logic [DATA_W-1:0]          rx_data
);
   localparam int LANES = DATA_W / LANE_W;

   if (LANE_W < 2 || (LANE_W % 2) != 0) begin : g_bad_lane
      $error("LANE_W must be even and at least 2");
   end
   if ((DATA_W % LANE_W) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of LANE_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tx_valid <= 1'b0;
      else        tx_valid <= in_valid;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
         .clk      (clk),
         .rst_n    (rst_n),
         .hist_clr (hist_clr),
         .in_valid (in_valid),
         .in_byte  (in_data[k*LANE_W +: LANE_W]),
         .line_byte(tx_line_data[k*LANE_W +: LANE_W]),
         .line_inv (tx_line_inv[k])
      );
      dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
         .line_byte(rx_line_data[k*LANE_W +: LANE_W]),
         .line_inv (rx_line_inv[k]),
         .data_byte(rx_data[k*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/dbi_ac_codec_chk.sv
module dbi_ac_codec_chk #(
   parameter int DATA_W = 128,
   parameter int LANE_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     hist_clr,
   input logic                     in_valid,
   input logic [DATA_W-1:0]        in_data,
   input logic                     tx_valid,
   input logic [DATA_W-1:0]        tx_line_data,
   input logic [DATA_W/LANE_W-1:0] tx_line_inv
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int HALF  = LANE_W / 2;

   logic [DATA_W-1:0] inv_mask;

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      assign inv_mask[k*LANE_W +: LANE_W] = {LANE_W{tx_line_inv[k]}};

      // R3
      toggle_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_valid && !$past(hist_clr)) |->
            ($countones({tx_line_data[k*LANE_W +: LANE_W], tx_line_inv[k]} ^
                        $past({tx_line_data[k*LANE_W +: LANE_W], tx_line_inv[k]})) <= HALF));
   end

   // R2
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> tx_valid);

   // R2
   idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !tx_valid);

   // R4
   decode_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ((tx_line_data ^ inv_mask) == $past(in_data)));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !hist_clr) |=> ($stable(tx_line_data) && $stable(tx_line_inv)));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_clr && !in_valid) |=> (tx_line_data == '0 && tx_line_inv == '0));
endmodule

bind dbi_ac_codec dbi_ac_codec_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dbi_ac_codec_test.sv
module dbi_ac_codec_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 128;
   localparam int NL = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hist_clr = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          tx_valid;
   logic [DW-1:0] tx_line_data;
   logic [NL-1:0] tx_line_inv;
   logic [DW-1:0] rx_data;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] m_data = '0;
   logic [NL-1:0] m_inv  = '0;
   logic [DW-1:0] o_data = '0;
   logic [NL-1:0] o_inv  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbi_ac_codec uut (
      .clk(clk), .rst_n(rst_n), .hist_clr(hist_clr), .in_valid(in_valid),
      .in_data(in_data), .tx_valid(tx_valid), .tx_line_data(tx_line_data),
      .tx_line_inv(tx_line_inv), .rx_line_data(tx_line_data),
      .rx_line_inv(tx_line_inv), .rx_data(rx_data)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One beat: drive at the falling edge, compare just after the rising edge.
   task automatic beat(input logic v, input logic c, input logic [DW-1:0] d, input string req);
      logic [DW-1:0] exp_rx;
      @(negedge clk);
      in_valid = v; hist_clr = c; in_data = d;
      o_data = tx_line_data; o_inv = tx_line_inv;
      @(posedge clk); #1;
      if (c) begin m_data = '0; m_inv = '0; end
      if (v) begin
         for (int k = 0; k < NL; k++) begin
            int cnt;
            logic inv;
            cnt = $countones(d[k*8 +: 8] ^ m_data[k*8 +: 8]);
            inv = (cnt > 4) || (cnt == 4 && m_inv[k]);
            m_data[k*8 +: 8] = inv ? ~d[k*8 +: 8] : d[k*8 +: 8];
            m_inv[k] = inv;
         end
      end
      check({req, " R2 valid"}, DW'(tx_valid), DW'(v));
      check({req, " R5 lines"}, tx_line_data, m_data);
      check({req, " R5 polarity"}, DW'(tx_line_inv), DW'(m_inv));
      exp_rx = v ? d : rx_data;
      if (v) begin
         check({req, " R4/R9 decode"}, rx_data, exp_rx);
         if (!c) begin
            for (int k = 0; k < NL; k++) begin
               int t;
               t = $countones({tx_line_data[k*8 +: 8], tx_line_inv[k]} ^ {o_data[k*8 +: 8], o_inv[k]});
               check({req, " R3 toggles<=4"}, DW'(t > 4), '0);
            end
         end
      end
      in_valid = 1'b0; hist_clr = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 reset lines", tx_line_data, '0);
      check("R1 reset polarity", DW'(tx_line_inv), '0);
      check("R1 reset valid", DW'(tx_valid), '0);
   endtask

   task automatic t_threshold;
      beat(1'b1, 1'b1, '0, "R7 clr-with-valid");
      // lane0: 4 diffs, prior flag 0 -> true; lane1: 5 diffs -> invert; lane2: 3 -> true
      beat(1'b1, 1'b0, {104'h0, 8'h07, 8'h1F, 8'h0F}, "R5 thresholds");
      check("R5 lane0 true", DW'(tx_line_data[7:0]), DW'(8'h0F));
      check("R5 lane1 inverted", DW'(tx_line_data[15:8]), DW'(8'hE0));
      check("R5 lane2 true", DW'(tx_line_data[23:16]), DW'(8'h07));
      check("R5 polarity bits", DW'(tx_line_inv[2:0]), DW'(3'b010));
      // lane1 tie: 4 diffs from E0 with prior flag 1 -> invert to 10
      beat(1'b1, 1'b0, {104'h0, 8'h07, 8'hEF, 8'h0F}, "R5 tie");
      check("R5 tie inverted", DW'(tx_line_data[15:8]), DW'(8'h10));
      check("R5 tie polarity", DW'(tx_line_inv[1]), DW'(1'b1));
   endtask

   task automatic t_idle_history;
      logic [DW-1:0] held;
      held = tx_line_data;
      beat(1'b0, 1'b0, {DW{1'b1}}, "R6 idle");
      beat(1'b0, 1'b0, {DW{1'b0}}, "R6 idle");
      check("R6 hold", tx_line_data, held);
      beat(1'b1, 1'b0, {104'h0, 8'h07, 8'hEF, 8'h0F}, "R8 after gap");
      check("R8 repeat codes same", tx_line_data, held);
   endtask

   task automatic t_clear;
      beat(1'b0, 1'b1, '1, "R7 clear alone");
      check("R7 cleared lines", tx_line_data, '0);
      check("R7 cleared polarity", DW'(tx_line_inv), '0);
      beat(1'b1, 1'b0, '1, "R7 all ones vs zero");
      check("R7 ones sent inverted", tx_line_data, '0);
      check("R7 ones polarity", DW'(tx_line_inv), DW'({NL{1'b1}}));
      beat(1'b1, 1'b0, '0, "R10 zeros");
   endtask

   task automatic t_lanes;
      // Lanes alternate between a pattern that inverts and one that does not.
      beat(1'b1, 1'b1, '0, "R10 base");
      beat(1'b1, 1'b0, {8{16'h03FC}}, "R10 mixed");
      for (int k = 0; k < NL; k++)
         check("R10 lane polarity", DW'(tx_line_inv[k]), DW'(k % 2 == 1 ? 1'b0 : 1'b1));
   endtask

   task automatic t_bursts;
      for (int i = 0; i < 300; i++) begin
         logic [DW-1:0] d;
         d = {$urandom, $urandom, $urandom, $urandom};
         beat(1'b1, 1'b0, d, "R8 burst beat0");
         beat(1'b1, 1'b0, d ^ {4{$urandom}}, "R8 burst beat1");
         if (i % 3 == 0) beat(1'b0, 1'b0, '0, "R6 gap");
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_threshold();
      t_idle_history();
      t_clear();
      t_lanes();
      t_bursts();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule